// File: doc/BRIEF.md
# Next-Program-Counter Unit

This block owns the program counter of a 32-bit load/store core and works out, for each instruction handed to it, where execution goes next. It decodes the major opcode, the second register-specifier field and the low immediate bits of the instruction word. From these it checks a branch condition: either two register values are compared for equality, or one register value is tested for its sign or for zero. It also forms two kinds of target. A PC-relative branch target counts words from the instruction that follows. A region-local jump target keeps the top four PC bits and replaces the rest.

The core presents one instruction word together with the two register values it names, and raises `step_i` for one cycle. On that clock edge the counter moves to its next value, and a flag records whether control flow was redirected. The unit has no back-pressure: it accepts an instruction in every cycle in which `step_i` is high. When `step_i` is low, the counter and the flag hold their values. Reset loads a parameterised start address, which is 0x00400000 by default.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it, `pc_o` equals `START_PC` and `taken_o` is 0.
- R2: Opcode (bits 31:26) 4 redirects when `rs_val_i == rt_val_i`; opcode 5 redirects when they differ.
- R3: Opcode 6 redirects when `rs_val_i`, read as signed, is ≤ 0; opcode 7 redirects when it is > 0. Bits 20:16 are not consulted for these opcodes.
- R4: Opcode 1 with bits 20:16 = 0 redirects when `rs_val_i` is negative; with bits 20:16 = 1 it redirects when `rs_val_i` is zero or positive.
- R5: A redirecting branch loads `pc_o + 4 + (sign-extended bits 15:0 × 4)`, modulo 2^32, which reaches −32768 to +32767 words from the following instruction.
- R6: A branch whose condition is false loads `pc_o + 4` and clears `taken_o`.
- R7: Opcode 2 always redirects, to {`pc_o`[31:28], bits 25:0, 2'b00}; the top four PC bits never change across it.
- R8: Any other opcode, and opcode 1 with bits 20:16 not 0 or 1, loads `pc_o + 4` with `taken_o` = 0.
- R9: While `step_i` is low, `pc_o` and `taken_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Accept the instruction this cycle and advance |
| insn_i | input | 32 | Instruction word at the current PC |
| rs_val_i | input | 32 | Value of the first named register |
| rt_val_i | input | 32 | Value of the second named register |
| pc_o | output | 32 | Current program counter |
| taken_o | output | 1 | Last accepted instruction redirected control flow |

## Verification
Both results are registered, so the new counter and flag are due at the first rising edge after a cycle in which `step_i` is high, and not before. The bench drives each instruction on a falling edge, lets exactly one rising edge pass, and compares on the next falling edge against a target worked out from the PC it has been tracking. Hold behaviour is checked by sampling across several edges with `step_i` low.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN   = 32;
  localparam int OPC_W  = 6;
  localparam int REG_W  = 5;
  localparam int OFF_W  = 16;
  localparam int IDX_W  = 26;
  localparam int REGION_W = XLEN - IDX_W - 2;

  localparam logic [OPC_W-1:0] OPC_ZCMP = 6'd1;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'd2;
  localparam logic [OPC_W-1:0] OPC_EQ   = 6'd4;
  localparam logic [OPC_W-1:0] OPC_NE   = 6'd5;
  localparam logic [OPC_W-1:0] OPC_LEZ  = 6'd6;
  localparam logic [OPC_W-1:0] OPC_GTZ  = 6'd7;

  localparam logic [REG_W-1:0] SEL_NEG  = 5'd0;
  localparam logic [REG_W-1:0] SEL_NNEG = 5'd1;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [REG_W-1:0] sel_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  output logic             is_br_o,
  output logic             hit_o
);
  logic neg, zero, same;

  assign neg  = a_i[XLEN-1];
  assign zero = (a_i == '0);
  assign same = (a_i == b_i);

  always_comb begin
    is_br_o = 1'b1;
    hit_o   = 1'b0;
    unique case (opc_i)
      OPC_EQ:  hit_o = same;
      OPC_NE:  hit_o = !same;
      OPC_LEZ: hit_o = neg || zero;
      OPC_GTZ: hit_o = !neg && !zero;
      OPC_ZCMP: begin
        if (sel_i == SEL_NEG)       hit_o = neg;
        else if (sel_i == SEL_NNEG) hit_o = !neg;
        else                        is_br_o = 1'b0;
      end
      default: is_br_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  br_o,
  output logic [XLEN-1:0]  jmp_o
);
  localparam int EXT_W = XLEN - OFF_W - 2;

  logic [XLEN-1:0] disp;

  assign seq_o = pc_i + XLEN'(4);
  assign disp  = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
  assign br_o  = seq_o + disp;
  assign jmp_o = {pc_i[XLEN-1 -: REGION_W], idx_i, 2'b00};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] START_PC = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_i,
  input  logic [31:0] insn_i,
  input  logic [31:0] rs_val_i,
  input  logic [31:0] rt_val_i,
  output logic [31:0] pc_o,
  output logic        taken_o
);
  logic [OPC_W-1:0] opc;
  logic             is_br, hit, is_jmp, redirect;
  logic [XLEN-1:0]  seq_pc, br_pc, jmp_pc, nxt_pc;

  assign opc    = insn_i[XLEN-1 -: OPC_W];
  assign is_jmp = (opc == OPC_JMP);

  npc_cond u_cond (
    .opc_i   (opc),
    .sel_i   (insn_i[OFF_W +: REG_W]),
    .a_i     (rs_val_i),
    .b_i     (rt_val_i),
    .is_br_o (is_br),
    .hit_o   (hit)
  );

  npc_target u_tgt (
    .pc_i  (pc_o),
    .off_i (insn_i[OFF_W-1:0]),
    .idx_i (insn_i[IDX_W-1:0]),
    .seq_o (seq_pc),
    .br_o  (br_pc),
    .jmp_o (jmp_pc)
  );

  assign redirect = is_jmp || (is_br && hit);

  always_comb begin
    if (is_jmp)             nxt_pc = jmp_pc;
    else if (is_br && hit)  nxt_pc = br_pc;
    else                    nxt_pc = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o    <= START_PC;
      taken_o <= 1'b0;
    end else if (step_i) begin
      pc_o    <= nxt_pc;
      taken_o <= redirect;
    end
  end

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(pc_o) && $stable(taken_o)));

  // R6
  fallthrough_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !hit && !is_jmp) |=> (pc_o == $past(pc_o) + 32'd4) && !taken_o);

  // R7
  jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && is_jmp) |=> (pc_o[31:28] == $past(pc_o[31:28])) && (pc_o[1:0] == 2'b00) && taken_o);

  // R8
  unknown_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !is_br && !is_jmp) |=> !taken_o);

  // R1
  reset_value_chk: assert property (@(posedge clk)
    !rst_n |=> (pc_o == START_PC) && !taken_o);
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  localparam logic [31:0] START = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [31:0] pc_o;
  logic        taken_o;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] model_pc;

  always #4 clk = ~clk;

  npc_unit #(.START_PC(START)) dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .insn_i(insn_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .pc_o(pc_o), .taken_o(taken_o)
  );

  function automatic logic [31:0] mk_b(input logic [5:0] op, input logic [4:0] sel, input logic [15:0] off);
    return {op, 5'd3, sel, off};
  endfunction

  function automatic logic [31:0] mk_j(input logic [25:0] idx);
    return {6'd2, idx};
  endfunction

  typedef struct packed {
    logic [31:0] insn;
    logic [31:0] a;
    logic [31:0] b;
    logic        tk;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{mk_b(6'd4, 5'd0, 16'h0003), 32'd5,        32'd5, 1'b1, 4'd2}, // R2 equal
    '{mk_b(6'd4, 5'd0, 16'h0003), 32'd5,        32'd6, 1'b0, 4'd2}, // R2 unequal
    '{mk_b(6'd5, 5'd0, 16'hFFFE), 32'd5,        32'd6, 1'b1, 4'd2}, // R2 differ
    '{mk_b(6'd5, 5'd0, 16'h0002), 32'd7,        32'd7, 1'b0, 4'd2}, // R2 same
    '{mk_b(6'd6, 5'd9, 16'h0001), 32'd0,        32'd1, 1'b1, 4'd3}, // R3 zero, sel ignored
    '{mk_b(6'd6, 5'd0, 16'h0004), 32'h8000_0000, 32'd0, 1'b1, 4'd3}, // R3 most negative
    '{mk_b(6'd6, 5'd0, 16'h0004), 32'd1,        32'd0, 1'b0, 4'd3}, // R3 positive
    '{mk_b(6'd7, 5'd0, 16'h0010), 32'd1,        32'd0, 1'b1, 4'd3}, // R3 one
    '{mk_b(6'd7, 5'd0, 16'h0010), 32'd0,        32'd0, 1'b0, 4'd3}, // R3 zero
    '{mk_b(6'd7, 5'd0, 16'h0010), 32'hFFFF_FFFF, 32'd0, 1'b0, 4'd3}, // R3 minus one
    '{mk_b(6'd1, 5'd0, 16'hFFF0), 32'hFFFF_FFFF, 32'd0, 1'b1, 4'd4}, // R4 negative
    '{mk_b(6'd1, 5'd0, 16'hFFF0), 32'd0,        32'd0, 1'b0, 4'd4}, // R4 zero not negative
    '{mk_b(6'd1, 5'd1, 16'h0020), 32'd0,        32'd0, 1'b1, 4'd4}, // R4 zero counts
    '{mk_b(6'd1, 5'd1, 16'h0020), 32'h8000_0000, 32'd0, 1'b0, 4'd4}, // R4 negative
    '{mk_b(6'd1, 5'd2, 16'h0020), 32'hFFFF_FFFF, 32'd0, 1'b0, 4'd8}, // R8 bad selector
    '{mk_b(6'h23, 5'd0, 16'h0020), 32'd0,       32'd0, 1'b0, 4'd8}, // R8 other opcode
    '{mk_j(26'h3FF_FFFF),          32'd0,       32'd0, 1'b1, 4'd7}, // R7 jump
    '{mk_b(6'd4, 5'd0, 16'h8000), 32'd1,        32'd1, 1'b1, 4'd5}, // R5 farthest back
    '{mk_b(6'd4, 5'd0, 16'h7FFF), 32'd1,        32'd1, 1'b1, 4'd5}  // R5 farthest forward
  };

  function automatic logic [31:0] expect_pc(input logic [31:0] pc, input logic [31:0] insn, input logic tk);
    if (!tk) return pc + 32'd4;
    if (insn[31:26] == 6'd2) return {pc[31:28], insn[25:0], 2'b00};
    return pc + 32'd4 + {{14{insn[15]}}, insn[15:0], 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] exp_pc, input logic exp_tk);
    n_run++;
    if (pc_o !== exp_pc || taken_o !== exp_tk) begin
      n_fail++;
      $display("FAIL %s: pc=%h taken=%b expected pc=%h taken=%b", req, pc_o, taken_o, exp_pc, exp_tk);
    end
  endtask

  task automatic issue(input logic [31:0] insn, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    insn_i = insn; rs_val_i = a; rt_val_i = b; step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", START, 1'b0);
    rst_n = 1'b1;
    model_pc = START;
    @(negedge clk);
    check("R9 idle after reset", model_pc, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] e;
      e = expect_pc(model_pc, VEC[i].insn, VEC[i].tk);
      issue(VEC[i].insn, VEC[i].a, VEC[i].b);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), e, VEC[i].tk);
      if (!VEC[i].tk) check("R6 fall-through", e, 1'b0);
      model_pc = e;
    end

    // R9: hold across idle edges even with a redirecting instruction present
    @(negedge clk);
    insn_i = mk_j(26'd0); step_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 hold", model_pc, 1'b1);

    // R7: walk sequentially into the next region, then jump keeps new top bits
    issue(mk_j(26'h3FF_FFFF), 0, 0);
    model_pc = {model_pc[31:28], 26'h3FF_FFFF, 2'b00};
    check("R7 jump to region end", model_pc, 1'b1);
    issue(32'hFC00_0000, 0, 0);
    model_pc = model_pc + 32'd4;
    check("R8 sequential into next region", model_pc, 1'b0);
    issue(mk_j(26'd0), 0, 0);
    check("R7 top bits kept", {model_pc[31:28], 28'd0}, 1'b1);

    // R1: reset mid-run returns to start
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", START, 1'b0);
    rst_n = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule